// File: doc/BRIEF.md
# Paged Memory Map Chip-Select Decoder

This block turns the top three address bits of an 8-bit processor's 16-bit bus into chip selects for the memory parts. It drives two ROM sockets (with the paged socket split into a low-page select and a game-page select), a RAM-visible strobe, and the top address bit fed to the DRAM multiplexer. A one-byte paging register chooses the memory map. It holds a mode flag that trades the bottom 16KB between ROM and RAM, a ROM page and a RAM page. Software writes this register over the data bus.

Two build parameters pick the populated parts. `ROM_SPLIT` chooses between a build of three 8KB ROMs (0) and a build of one 16KB ROM plus one 8KB ROM (1). `RAM_64K` chooses between 32KB of DRAM (0) and 64KB (1). A board strap, `strap_hide`, is a diagnostic option: when high it hides RAM outside the top 16KB. On one RAM page, the DRAM address bit is forced low so that the CPU window 0x8000-0xBFFF lands on DRAM 0x0000-0x3FFF.

The decode is combinational from the address, the strobes and the registered page state. There is no streaming data path, so every pin is plain control.

Top module: `memmap_decoder`

## Requirements
- R1: Reset clears the paging register to all zero. After reset, a memory read at 0x0000 asserts `rom_fixed_ce` and leaves `ram_sel` low.
- R2: The paging register loads `page_din` on a rising clock edge while `page_we` is high. Bit 7 is the RAM mode flag, bits 6:4 are the ROM page and bits 3:0 are the RAM page. The new map applies from the cycle after that edge.
- R3: No ROM enable asserts unless all three conditions hold: `mreq_n` is low, `rd_n` is low and the mode flag is 0.
- R4: `rom_fixed_ce` covers 0x0000-0x1FFF. In the 16KB+8KB build it also covers 0x2000-0x3FFF when the ROM page is 0.
- R5: In 0x2000-0x3FFF, `rom_low_ce` asserts for ROM page 1 in the 16KB+8KB build, and for ROM pages 0 or 1 in the three-8KB build. `rom_game_ce` asserts for ROM page 7. No ROM enable asserts for any other page, and at most one ROM enable is high at a time.
- R6: `ram_sel` asserts for 0xC000-0xFFFF whenever `mreq_n` is low, whatever the mode flag, the pages or the strap.
- R7: In the 32KB build, 0x8000-0xBFFF is RAM when the RAM page is 0, regardless of the strap. With the strap low there are two more windows. With mode 1 and RAM page 0, 0x0000-0x3FFF is also RAM. With mode 0 and RAM page 1, 0x8000-0xBFFF is RAM.
- R8: In the 64KB build with the strap low, three windows are RAM. Mode 1 with RAM page 0 makes all of 0x0000-0xFFFF RAM. Mode 0 with RAM page 0 makes 0x4000-0xBFFF RAM. Mode 0 with RAM page 1 makes 0x8000-0xBFFF RAM.
- R9: With `strap_hide` high, `ram_sel` asserts only in 0xC000-0xFFFF. The one exception is the RAM-page-0 window of R7 in the 32KB build.
- R10: `dram_a15` follows A15. It is forced low during a memory request when the mode flag is 0, the RAM page is 1 and the address is in 0x8000-0xBFFF.
- R11: `ram_sel` and any ROM enable never assert together, and nothing asserts while `mreq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the paging register |
| rst_n | input | 1 | Active-low reset, clears the paging register |
| addr_hi | input | 3 | CPU address bits A15..A13 |
| mreq_n | input | 1 | Active-low memory request |
| rd_n | input | 1 | Active-low read strobe |
| page_we | input | 1 | Load strobe for the paging register |
| page_din | input | 8 | Data bus value loaded into the paging register |
| strap_hide | input | 1 | Diagnostic strap; high hides RAM outside the top 16KB |
| rom_fixed_ce | output | 1 | Fixed ROM enable, active high |
| rom_low_ce | output | 1 | Paged ROM enable for the low pages, active high |
| rom_game_ce | output | 1 | Paged ROM enable for the game page, active high |
| ram_sel | output | 1 | RAM visible for this access, active high |
| dram_a15 | output | 1 | Top address bit presented to the DRAM multiplexer |

## Verification
The bench drives both builds with every address eighth, mode, ROM page, a spread of RAM pages including 0, 1 and 15, both strobes and the strap. Each output is compared against a behavioural map. A design that left the 32KB page-0 window gated by the strap would lose 0x8000-0xBFFF on strapped boards. One that gave ROM page 0 to the paged socket in the 16KB+8KB build would double-select it alongside the fixed ROM. A fold that ignored the mode flag would corrupt DRAM 0x0000-0x3FFF while ROM is mapped. Writes at 0x0000 check that ROM never answers a write, and the reset check confirms that ROM, not RAM, answers at 0x0000 when the machine starts.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int ROM_PAGE_W = 3;
  localparam int RAM_PAGE_W = 4;
  localparam int LATCH_W    = 1 + ROM_PAGE_W + RAM_PAGE_W;

  // bit order follows the data bus: mode on top, ROM page, RAM page at the bottom
  typedef struct packed {
    logic                  ram_mode;
    logic [ROM_PAGE_W-1:0] rom_page;
    logic [RAM_PAGE_W-1:0] ram_page;
  } page_state_t;

  // 16KB quarters of the CPU space, from A15..A14
  typedef enum logic [1:0] {
    QTR_LOW   = 2'b00,
    QTR_MID   = 2'b01,
    QTR_PAGED = 2'b10,
    QTR_TOP   = 2'b11
  } quarter_t;
endpackage

// File: rtl/memmap_page_latch.sv
module memmap_page_latch
  import memmap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] din,
  output page_state_t       state
);
  always_ff @(posedge clk) begin
    if (!rst_n)  state <= '0;
    else if (we) state <= page_state_t'(din[LATCH_W-1:0]);
  end

  // R2: a write lands in the next cycle
  assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (state == page_state_t'($past(din[LATCH_W-1:0]))));
  // R2: without a write the state holds
  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(state));
endmodule

// File: rtl/memmap_rom_decode.sv
module memmap_rom_decode
  import memmap_pkg::*;
#(
  parameter int ROM_SPLIT = 1,
  parameter int GAME_PAGE = 7
) (
  input  logic [2:0]            addr_hi,
  input  logic                  rd_act,
  input  logic                  ram_mode,
  input  logic [ROM_PAGE_W-1:0] rom_page,
  output logic                  fixed_ce,
  output logic                  low_ce,
  output logic                  game_ce
);
  localparam logic [ROM_PAGE_W-1:0] PG_ZERO = '0;
  localparam logic [ROM_PAGE_W-1:0] PG_ONE  = ROM_PAGE_W'(1);
  localparam logic [ROM_PAGE_W-1:0] PG_GAME = ROM_PAGE_W'(GAME_PAGE);

  logic rom_win, lo8, hi8;
  always_comb begin
    rom_win = rd_act && !ram_mode && (addr_hi[2:1] == 2'b00);
    lo8     = rom_win && !addr_hi[0];
    hi8     = rom_win &&  addr_hi[0];
  end

  generate
    if (ROM_SPLIT != 0) begin : g_split
      // 16KB part answers page 0 in the upper 8KB
      always_comb begin
        fixed_ce = lo8 || (hi8 && rom_page == PG_ZERO);
        low_ce   = hi8 && rom_page == PG_ONE;
      end
    end else begin : g_three
      always_comb begin
        fixed_ce = lo8;
        low_ce   = hi8 && (rom_page == PG_ZERO || rom_page == PG_ONE);
      end
    end
  endgenerate

  assign game_ce = hi8 && rom_page == PG_GAME;
endmodule

// File: rtl/memmap_ram_decode.sv
module memmap_ram_decode
  import memmap_pkg::*;
#(
  parameter int RAM_64K = 1
) (
  input  quarter_t              quarter,
  input  logic                  mem_act,
  input  logic                  strap_hide,
  input  logic                  ram_mode,
  input  logic [RAM_PAGE_W-1:0] ram_page,
  output logic                  ram_sel,
  output logic                  dram_a15
);
  logic pg0, pg1, q_low, q_mid, q_paged, q_top, fold, extra;

  always_comb begin
    pg0     = ram_page == '0;
    pg1     = ram_page == RAM_PAGE_W'(1);
    q_low   = quarter == QTR_LOW;
    q_mid   = quarter == QTR_MID;
    q_paged = quarter == QTR_PAGED;
    q_top   = quarter == QTR_TOP;
    fold    = mem_act && !ram_mode && pg1 && q_paged;
    dram_a15 = quarter[1] && !fold;
  end

  generate
    if (RAM_64K != 0) begin : g_big
      always_comb begin
        extra = !strap_hide && ((ram_mode && pg0) ||
                                (!ram_mode && pg0 && (q_mid || q_paged)) ||
                                (!ram_mode && pg1 && q_paged));
      end
    end else begin : g_small
      // page-0 window in the third quarter is not gated by the strap
      always_comb begin
        extra = (pg0 && q_paged) ||
                (!strap_hide && ((ram_mode && pg0 && (q_low || q_paged)) ||
                                 (!ram_mode && pg1 && q_paged)));
      end
    end
  endgenerate

  assign ram_sel = mem_act && (q_top || extra);
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int ROM_SPLIT = 1,
  parameter int RAM_64K   = 1,
  parameter int DATA_W    = 8,
  parameter int GAME_PAGE = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        addr_hi,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              page_we,
  input  logic [DATA_W-1:0] page_din,
  input  logic              strap_hide,
  output logic              rom_fixed_ce,
  output logic              rom_low_ce,
  output logic              rom_game_ce,
  output logic              ram_sel,
  output logic              dram_a15
);
  page_state_t state;
  logic        mem_act, rd_act;
  quarter_t    quarter;

  assign mem_act = !mreq_n;
  assign rd_act  = !mreq_n && !rd_n;
  assign quarter = quarter_t'(addr_hi[2:1]);

  memmap_page_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .we(page_we), .din(page_din), .state(state)
  );

  memmap_rom_decode #(.ROM_SPLIT(ROM_SPLIT), .GAME_PAGE(GAME_PAGE)) u_rom (
    .addr_hi(addr_hi), .rd_act(rd_act), .ram_mode(state.ram_mode),
    .rom_page(state.rom_page), .fixed_ce(rom_fixed_ce), .low_ce(rom_low_ce),
    .game_ce(rom_game_ce)
  );

  memmap_ram_decode #(.RAM_64K(RAM_64K)) u_ram (
    .quarter(quarter), .mem_act(mem_act), .strap_hide(strap_hide),
    .ram_mode(state.ram_mode), .ram_page(state.ram_page),
    .ram_sel(ram_sel), .dram_a15(dram_a15)
  );

  logic rom_any;
  assign rom_any = rom_fixed_ce || rom_low_ce || rom_game_ce;

  assert_rom_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rom_any |-> (!mreq_n && !rd_n && !state.ram_mode));
  assert_rom_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_fixed_ce, rom_low_ce, rom_game_ce}));
  assert_top_ram_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && addr_hi[2:1] == 2'b11) |-> ram_sel);
  assert_strap_hide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (RAM_64K != 0 && strap_hide && addr_hi[2:1] != 2'b11) |-> !ram_sel);
  assert_low_half_a15_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hi[2] |-> !dram_a15);
  assert_no_clash_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_any && ram_sel));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> !(rom_any || ram_sel));
endmodule

// File: tb/memmap_decoder_test.sv
module memmap_decoder_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr_hi = '0;
  logic mreq_n = 1'b1, rd_n = 1'b1, page_we = 1'b0, strap_hide = 1'b0;
  logic [7:0] page_din = '0;
  logic a_fix, a_low, a_game, a_ram, a_d15;
  logic b_fix, b_low, b_game, b_ram, b_d15;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  // bench model of the paging register
  bit m_mode = 0;
  int m_rp = 0, m_mp = 0;

  always #(PERIOD/2) clk = ~clk;

  // 16KB+8KB ROM, 64KB RAM
  memmap_decoder #(.ROM_SPLIT(1), .RAM_64K(1)) uut (
    .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .mreq_n(mreq_n), .rd_n(rd_n),
    .page_we(page_we), .page_din(page_din), .strap_hide(strap_hide),
    .rom_fixed_ce(a_fix), .rom_low_ce(a_low), .rom_game_ce(a_game),
    .ram_sel(a_ram), .dram_a15(a_d15));

  // three 8KB ROMs, 32KB RAM
  memmap_decoder #(.ROM_SPLIT(0), .RAM_64K(0)) uut_alt (
    .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .mreq_n(mreq_n), .rd_n(rd_n),
    .page_we(page_we), .page_din(page_din), .strap_hide(strap_hide),
    .rom_fixed_ce(b_fix), .rom_low_ce(b_low), .rom_game_ce(b_game),
    .ram_sel(b_ram), .dram_a15(b_d15));

  // returns {fixed, low, game, ram, a15}
  function automatic logic [4:0] ref_map(bit split, bit big, bit mode, int rp, int mp,
                                         int a, bit mq_n, bit r_n, bit strap);
    int base = a * 8192;
    bit rd = !mode && !mq_n && !r_n;
    bit fix = 0, lo = 0, gm = 0, ram = 0, d15;
    bit in_hi8 = (base >= 'h2000 && base < 'h4000);
    bit in_win = (base >= 'h8000 && base < 'hC000);
    if (rd && base < 'h2000) fix = 1;
    if (rd && in_hi8) begin
      if (split && rp == 0) fix = 1;
      if (split ? (rp == 1) : (rp <= 1)) lo = 1;
      if (rp == 7) gm = 1;
    end
    if (!mq_n) begin
      if (base >= 'hC000) ram = 1;
      if (big) begin
        if (!strap && mode && mp == 0) ram = 1;
        if (!strap && !mode && mp == 0 && base >= 'h4000 && base < 'hC000) ram = 1;
        if (!strap && !mode && mp == 1 && in_win) ram = 1;
      end else begin
        if (mp == 0 && in_win) ram = 1;
        if (!strap && mode && mp == 0 && (base < 'h4000 || in_win)) ram = 1;
        if (!strap && !mode && mp == 1 && in_win) ram = 1;
      end
    end
    d15 = (base >= 'h8000) && !(!mode && mp == 1 && in_win && !mq_n);
    return {fix, lo, gm, ram, d15};
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b (mode=%0d rp=%0d mp=%0d a=%0d mreq_n=%b rd_n=%b strap=%b)",
               tag, what, act, exp, m_mode, m_rp, m_mp, addr_hi, mreq_n, rd_n, strap_hide);
    end
  endtask

  task automatic compare_one(string nm, bit split, bit big, logic [4:0] got);
    logic [4:0] e;
    string rtag, mtag;
    e = ref_map(split, big, m_mode, m_rp, m_mp, addr_hi, mreq_n, rd_n, strap_hide);
    rtag = (m_mode || mreq_n || rd_n) ? "R3" : "R4";
    chk(rtag, {nm, " rom_fixed_ce"}, got[4], e[4]);
    rtag = (m_mode || mreq_n || rd_n) ? "R3" : "R5";
    chk(rtag, {nm, " rom_low_ce"}, got[3], e[3]);
    chk(rtag, {nm, " rom_game_ce"}, got[2], e[2]);
    if (!mreq_n && addr_hi[2:1] == 2'b11) mtag = "R6";
    else if (strap_hide) mtag = "R9";
    else mtag = big ? "R8" : "R7";
    chk(mtag, {nm, " ram_sel"}, got[1], e[1]);
    chk("R10", {nm, " dram_a15"}, got[0], e[0]);
    chk("R11", {nm, " rom/ram overlap"}, (|got[4:2]) && got[1], 1'b0);
  endtask

  task automatic write_page(bit mode, int rp, int mp);
    @(negedge clk);
    page_din = {mode, 3'(rp), 4'(mp)};
    page_we = 1'b1;
    @(negedge clk);
    page_we = 1'b0;
    m_mode = mode; m_rp = rp; m_mp = mp;
  endtask

  task automatic apply(int a, bit mq_n, bit r_n, bit strap);
    @(negedge clk);
    addr_hi = 3'(a); mreq_n = mq_n; rd_n = r_n; strap_hide = strap;
    #(PERIOD/4);
    compare_one("uut", 1, 1, {a_fix, a_low, a_game, a_ram, a_d15});
    compare_one("uut_alt", 0, 0, {b_fix, b_low, b_game, b_ram, b_d15});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: after reset ROM answers at 0x0000
    @(negedge clk);
    addr_hi = 3'd0; mreq_n = 1'b0; rd_n = 1'b0; strap_hide = 1'b0;
    #(PERIOD/4);
    chk("R1", "uut fixed rom after reset", a_fix, 1'b1);
    chk("R1", "uut ram after reset", a_ram, 1'b0);
    chk("R1", "uut_alt fixed rom after reset", b_fix, 1'b1);
    chk("R1", "uut_alt ram after reset", b_ram, 1'b0);
    // R2: write mode=1 page 0 turns 0x0000 into RAM on the next cycle
    write_page(1'b1, 0, 0);
    #(PERIOD/4);
    chk("R2", "uut ram after load", a_ram, 1'b1);
    chk("R2", "uut rom after load", a_fix, 1'b0);
    chk("R2", "uut_alt ram after load", b_ram, 1'b1);
    // R3: a write at 0x0000 never selects ROM
    write_page(1'b0, 0, 0);
    apply(0, 1'b0, 1'b1, 1'b0);
    // full sweep
    for (int md = 0; md < 2; md++)
      for (int rp = 0; rp < 8; rp++)
        for (int mi = 0; mi < 4; mi++) begin
          int mp = (mi == 3) ? 15 : mi;
          write_page(md[0], rp, mp);
          for (int a = 0; a < 8; a++)
            for (int s = 0; s < 8; s++)
              apply(a, s[0], s[1], s[2]);
        end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule